// File: doc/BRIEF.md
# Segmented Load Deinterleave Sequencer

This block steers a unit-stride segmented vector load into the vector register file. A segment is a group of NF adjacent fields in memory, for example the real and imaginary halves of a complex sample. The elements arrive one at a time in memory order on a valid/ready stream. The sequencer sends every field to its own register group. Group f begins at base + f × EMUL. Element i of a field lands in register `base + f*EMUL + i/8`, slot `i%8`, because a 256-bit register holds eight 32-bit elements.

A command is the base register, the field count NF, the group multiplier EMUL and the vector length VL. The block checks every command before it starts. A command it cannot carry out is refused with a one-cycle illegal flag, and no register is written. An accepted command runs until VL × NF elements have been taken. A one-cycle done pulse then marks the end, and the block returns to idle. Write ports are driven in the same cycle as the handshake: `wr_en` equals `in_valid && in_ready`.

Top module: `segld_seq`

## Requirements
- R1: Elements are taken in memory order. The field index steps 0,1,…,NF-1, and after each wrap the element index advances by one.
- R2: Element i of field f is written with `wr_reg = base + f*EMUL + i/8`, `wr_slot = i%8` and `wr_data` equal to the accepted stream word, in the same cycle as its handshake.
- R3: A command with EMUL × NF > 8 raises `illegal` for exactly the cycle after `start`. It writes nothing and leaves `in_ready` low.
- R4: A command is illegal under the same rule as R3 if `base` is not a multiple of EMUL, or if base + EMUL × NF > 32.
- R5: A command is illegal under the same rule as R3 if NF is outside 2..8, if EMUL is not one of 1, 2, 4, 8, or if VL > EMUL × 8. NF and EMUL are given as plain binary numbers.
- R6: `done` is high for exactly the one cycle after the final element's handshake. In that same cycle `in_ready` is low.
- R7: While `in_valid` is low during a run, no write occurs and no element is lost or reordered.
- R8: A `start` that arrives during a run is ignored. The run keeps its own command, and nothing is queued after it.
- R9: After reset the block is idle, with `in_ready`, `done`, `illegal` and `wr_en` all low.
- R10: A legal command with VL = 0 writes nothing and pulses `done` in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, sampled only when idle |
| cmd_base | input | 5 | First destination register |
| cmd_nf | input | 4 | Fields per segment |
| cmd_emul | input | 4 | Registers per field group |
| cmd_vl | input | 7 | Elements per field |
| in_valid | input | 1 | Stream element valid |
| in_data | input | 32 | Stream element |
| in_ready | output | 1 | High while a run is active |
| wr_en | output | 1 | Register file write strobe |
| wr_reg | output | 5 | Register file write index |
| wr_slot | output | 3 | Element slot within the register |
| wr_data | output | 32 | Write data |
| done | output | 1 | End-of-run pulse |
| illegal | output | 1 | Refused-command pulse |

## Verification
The bench targets the group boundary where the element index crosses from slot 7 into the next register with EMUL = 4 and EMUL = 2. A design that forgot the `i/8` term there would write over the first register of the group. It also uses the largest legal span, NF = 8, to catch a field counter that wraps too early or too late, which would shift every later element onto the wrong field. Each illegal case is tried on its own with a live stream applied: EMUL = 8 with two fields, misalignment, running past register 31, NF = 1, EMUL = 3 and VL too long. A design that let any of them through would show writes or raise `in_ready`. Stalls, a `start` issued mid-run and VL = 0 test that the cursor holds its place, that the running command is kept, and that the empty case does not hang.

// File: rtl/segld_pkg.sv
package segld_pkg;

    localparam int VLEN      = 256;
    localparam int SEW       = 32;
    localparam int NUM_VREGS = 32;
    localparam int MAX_GROUP = 8;

    localparam int EPR    = VLEN / SEW;
    localparam int SLOT_W = $clog2(EPR);
    localparam int REG_W  = $clog2(NUM_VREGS);
    localparam int VL_W   = $clog2(MAX_GROUP * EPR + 1);
    localparam int NF_W   = 4;
    localparam int EMUL_W = 4;

    typedef struct packed {
        logic [REG_W-1:0]  base;
        logic [NF_W-1:0]   nf;
        logic [EMUL_W-1:0] emul;
        logic [VL_W-1:0]   vl;
    } seg_cmd_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seg_state_e;

    function automatic logic cmd_legal(seg_cmd_t c);
        int e;
        int n;
        int b;
        int v;
        e = int'(c.emul);
        n = int'(c.nf);
        b = int'(c.base);
        v = int'(c.vl);
        if (!(e == 1 || e == 2 || e == 4 || e == 8)) return 1'b0;
        if (n < 2 || n > 8)                          return 1'b0;
        if (e * n > MAX_GROUP)                       return 1'b0;
        if ((b % e) != 0)                            return 1'b0;
        if (b + e * n > NUM_VREGS)                   return 1'b0;
        if (v > e * EPR)                             return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/segld_legal.sv
module segld_legal
    import segld_pkg::*;
(
    input  seg_cmd_t cmd,
    output logic     ok
);
    always_comb ok = cmd_legal(cmd);
endmodule

// File: rtl/segld_cursor.sv
module segld_cursor
    import segld_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  seg_cmd_t         cmd,
    input  logic             step,
    output logic [REG_W-1:0] reg_idx,
    output logic [SLOT_W-1:0] slot,
    output logic             last
);
    logic [NF_W-1:0]   fld;
    logic [VL_W-1:0]   idx;
    logic [REG_W-1:0]  grp;
    seg_cmd_t          held;

    always_ff @(posedge clk) begin
        if (rst) begin
            fld  <= '0;
            idx  <= '0;
            grp  <= '0;
            held <= '0;
        end else if (load) begin
            fld  <= '0;
            idx  <= '0;
            grp  <= cmd.base;
            held <= cmd;
        end else if (step) begin
            if (fld == held.nf - 1'b1) begin
                fld <= '0;
                grp <= held.base;
                idx <= idx + 1'b1;
            end else begin
                fld <= fld + 1'b1;
                grp <= grp + REG_W'(held.emul);
            end
        end
    end

    always_comb begin
        reg_idx = grp + REG_W'(idx >> SLOT_W);
        slot    = idx[SLOT_W-1:0];
        last    = (fld == held.nf - 1'b1) && (idx == held.vl - 1'b1);
    end

    // R7: with no load and no step the cursor keeps its position
    assert_cursor_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> ($stable(fld) && $stable(idx)));

    // R2: every write lands inside the command's register span
    assert_write_in_span_R2: assert property (@(posedge clk) disable iff (rst)
        step |-> ((int'(reg_idx) >= int'(held.base)) &&
                  (int'(reg_idx) < int'(held.base) + int'(held.emul) * int'(held.nf))));

    // R1: field index wraps at NF-1 and advances the element index
    assert_field_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (step && !load && fld == held.nf - 1'b1) |=> (fld == '0 && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/segld_seq.sv
module segld_seq
    import segld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REG_W-1:0]  cmd_base,
    input  logic [NF_W-1:0]   cmd_nf,
    input  logic [EMUL_W-1:0] cmd_emul,
    input  logic [VL_W-1:0]   cmd_vl,
    input  logic              in_valid,
    input  logic [SEW-1:0]    in_data,
    output logic              in_ready,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_reg,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SEW-1:0]    wr_data,
    output logic              done,
    output logic              illegal
);
    seg_cmd_t   cmd;
    seg_state_e state;
    logic       legal;
    logic       accept;
    logic       fire;
    logic       last;
    logic       done_q;
    logic       illegal_q;

    always_comb begin
        cmd.base = cmd_base;
        cmd.nf   = cmd_nf;
        cmd.emul = cmd_emul;
        cmd.vl   = cmd_vl;
    end

    segld_legal u_legal (
        .cmd (cmd),
        .ok  (legal)
    );

    assign accept = start && (state == ST_IDLE);
    assign fire   = in_valid && (state == ST_RUN);

    segld_cursor u_cursor (
        .clk     (clk),
        .rst     (rst),
        .load    (accept && legal),
        .cmd     (cmd),
        .step    (fire),
        .reg_idx (wr_reg),
        .slot    (wr_slot),
        .last    (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            if (accept) begin
                if (!legal)
                    illegal_q <= 1'b1;
                else if (cmd_vl == '0)
                    done_q <= 1'b1;
                else
                    state <= ST_RUN;
            end else if (fire && last) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
            end
        end
    end

    assign in_ready = (state == ST_RUN);
    assign wr_en    = fire;
    assign wr_data  = in_data;
    assign done     = done_q;
    assign illegal  = illegal_q;

    // R3 R4 R5: a refused command flags illegal and never opens the stream
    assert_illegal_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !legal) |=> (illegal && !in_ready && !wr_en));

    // R6: done is a single pulse and the stream is closed while it is high
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_closed_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

    // R8: a start during a run that is not the last element keeps the run going
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (start && in_ready && !(fire && last)) |=> (in_ready && !illegal));

    // R10: a legal empty command completes at once
    assert_empty_done_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && legal && cmd_vl == '0) |=> (done && !in_ready));
endmodule

// File: tb/segld_seq_bench.sv
module segld_seq_bench;
    import segld_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [REG_W-1:0]  cmd_base = '0;
    logic [NF_W-1:0]   cmd_nf = '0;
    logic [EMUL_W-1:0] cmd_emul = '0;
    logic [VL_W-1:0]   cmd_vl = '0;
    logic              in_valid = 1'b0;
    logic [SEW-1:0]    in_data = '0;
    logic              in_ready;
    logic              wr_en;
    logic [REG_W-1:0]  wr_reg;
    logic [SLOT_W-1:0] wr_slot;
    logic [SEW-1:0]    wr_data;
    logic              done;
    logic              illegal;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    segld_seq u_segld_seq (
        .clk(clk), .rst(rst), .start(start),
        .cmd_base(cmd_base), .cmd_nf(cmd_nf), .cmd_emul(cmd_emul), .cmd_vl(cmd_vl),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_slot(wr_slot), .wr_data(wr_data),
        .done(done), .illegal(illegal)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog R6 act=%0d exp=%0d", cyc, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_cmd(input int base, input int nf, input int emul, input int vl);
        cmd_base = REG_W'(base);
        cmd_nf   = NF_W'(nf);
        cmd_emul = EMUL_W'(emul);
        cmd_vl   = VL_W'(vl);
    endtask

    // Legal run; optional stalls (R7) and a stray mid-run start (R8)
    task automatic run_load(input int base, input int nf, input int emul, input int vl,
                            input bit stall, input bit poke);
        @(negedge clk);
        drive_cmd(base, nf, emul, vl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (vl == 0) begin
            chk(done && !in_ready && !wr_en, "R10 empty done", {done, in_ready, wr_en}, 3'b100);
            @(negedge clk);
            chk(!done, "R10 done single", done, 0);
            return;
        end
        chk(in_ready, "R1 run open", in_ready, 1);
        for (int i = 0; i < vl; i++) begin
            for (int f = 0; f < nf; f++) begin
                int er;
                logic [SEW-1:0] pat;
                if (stall && ((i + f) % 3 == 1)) begin
                    in_valid = 1'b0;
                    in_data  = 32'hDEAD_BEEF;
                    #1;
                    chk(!wr_en && in_ready, "R7 stall no write", {wr_en, in_ready}, 2'b01);
                    @(negedge clk);
                end
                if (poke && i == 0 && f == 1) begin
                    drive_cmd(0, 2, 1, 1);
                    start = 1'b1;
                end
                pat = 32'hA000_0000 | (base << 16) | (f << 8) | i;
                er  = base + f * emul + i / EPR;
                in_valid = 1'b1;
                in_data  = pat;
                #1;
                chk(wr_en && int'(wr_reg) == er && int'(wr_slot) == i % EPR && wr_data == pat,
                    "R1 R2 element placement",
                    {wr_en, 3'b0, wr_reg, 5'b0, wr_slot, wr_data},
                    {1'b1, 3'b0, 5'(er), 5'b0, 3'(i % EPR), pat});
                @(negedge clk);
                start = 1'b0;
            end
        end
        in_valid = 1'b0;
        #1;
        chk(done && !in_ready, "R6 done after last", {done, in_ready}, 2'b10);
        @(negedge clk);
        chk(!done && !in_ready, "R6 done single R8 nothing queued", {done, in_ready}, 2'b00);
    endtask

    task automatic bad_cmd(input int base, input int nf, input int emul, input int vl,
                           input string tag);
        @(negedge clk);
        drive_cmd(base, nf, emul, vl);
        start    = 1'b1;
        in_valid = 1'b1;
        in_data  = 32'h5555_AAAA;
        @(negedge clk);
        start = 1'b0;
        chk(illegal && !in_ready && !wr_en && !done, tag,
            {illegal, in_ready, wr_en, done}, 4'b1000);
        @(negedge clk);
        chk(!illegal && !in_ready && !wr_en, tag, {illegal, in_ready, wr_en}, 3'b000);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!in_ready && !done && !illegal && !wr_en, "R9 reset idle",
            {in_ready, done, illegal, wr_en}, 4'b0000);

        run_load(0, 2, 1, 8, 1'b0, 1'b0);    // R2 base and base+1
        run_load(8, 2, 4, 32, 1'b0, 1'b0);   // R2 groups of four
        run_load(16, 3, 2, 13, 1'b1, 1'b0);  // R7 stalls, partial group
        run_load(0, 8, 1, 5, 1'b1, 1'b0);    // R1 eight fields
        run_load(24, 2, 2, 4, 1'b0, 1'b1);   // R8 stray start
        run_load(4, 2, 1, 0, 1'b0, 1'b0);    // R10 empty

        bad_cmd(0, 2, 8, 8,  "R3 emul8 two fields");
        bad_cmd(0, 3, 4, 1,  "R3 span twelve");
        bad_cmd(2, 2, 4, 4,  "R4 misaligned base");
        bad_cmd(28, 2, 4, 4, "R4 past last register");
        bad_cmd(0, 1, 1, 1,  "R5 one field");
        bad_cmd(0, 9, 1, 1,  "R5 nine fields");
        bad_cmd(0, 2, 3, 1,  "R5 emul three");
        bad_cmd(0, 2, 1, 9,  "R5 vl too long");

        run_load(30, 2, 1, 3, 1'b1, 1'b0);   // R4 highest legal span after refusals

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule